// File: doc/BRIEF.md
# Byte-Wide Rewritable Memory Mode Decoder

This block is a synthesizable behavioural model of a small byte-wide memory that is rewritten only by a dedicated programmer. Its operating mode is decoded from three active-low strobes: chip enable, write enable and output enable. Two flags widen that decode. Each one reports that a high voltage is present on a pin that normally has another job: one on the output-enable pin and one on address bit 9. Because the model's address bus is narrower than bit 9, the address-9 sense arrives only as a flag.

The model provides read, output disable, standby, whole-array erase, byte program and identifier readout. Write enable is sampled on the system clock. A program or erase is applied once, on the clock edge at which a falling write-enable edge is seen. Erase can only set bits and program can only clear them, so rewriting a location needs an erase first. The data bus is an 8-bit output with a separate drive-enable, which a pad ring uses for tri-state control.

Top module: `byte_store_model`

## Requirements
- R1: The bus is driven (dataOe = 1) exactly when chipEnN = 0, outEnN = 0 and outEnHv = 0. In every other case dataOe = 0.
- R2: While chipEnN = 1 the block is in standby. The bus floats and no write-enable edge alters the array.
- R3: Erase is selected by chipEnN = 0, outEnHv = 1 and addrHv = 1. It is started by a falling edge of writeEnN, and the address and data inputs have no effect on it.
- R4: After an erase every byte of the array reads FFh.
- R5: Program is selected by chipEnN = 0, outEnHv = 1 and addrHv = 0. A falling edge of writeEnN writes dataIn to the location selected by addr.
- R6: Identifier readout is selected by chipEnN = 0, outEnN = 0, writeEnN = 1, outEnHv = 0 and addrHv = 1. With addr = 0 the bus returns the maker code MAKER_CODE (default BFh). With addr = 1 it returns DEVICE_CODE (default C5h). With any addr bit above bit 0 set it returns 00h.
- R7: While writeEnN = 1 the array never changes, whatever the other inputs are.
- R8: A program stores the bitwise AND of the old byte and dataIn, so it can only clear bits.
- R9: writeEnN is sampled on clk and each falling edge applies at most one operation. Holding writeEnN low, or changing dataIn while it is low, has no further effect.
- R10: Reset (rstN = 0) loads every byte of the array with FFh.
- R11: In read mode (chipEnN = 0, outEnN = 0, outEnHv = 0, addrHv = 0) the bus returns the byte stored at addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; write enable is sampled on its rising edge |
| rstN | input | 1 | Active-low reset; fills the array with FFh |
| chipEnN | input | 1 | Active-low chip enable |
| writeEnN | input | 1 | Active-low write enable; its falling edge starts program or erase |
| outEnN | input | 1 | Active-low output enable |
| outEnHv | input | 1 | High voltage sensed on the output-enable pin |
| addrHv | input | 1 | High voltage sensed on address bit 9 |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Byte to program |
| dataOut | output | 8 | Byte presented to the bus |
| dataOe | output | 1 | Bus drive enable for the tri-state pad |

## Verification
The hardest case to reach from the ports is a write-enable pulse that lasts several clock cycles while the input byte changes inside the pulse. Only the value present on the cycle of the falling edge may be written. The bench holds writeEnN low across several cycles and swaps dataIn midway. It picks the two bytes so that their AND differs from the first byte alone, and then reads the location back. Identifier readout with stray upper address bits, and erase with garbage on the address and data inputs, are reached the same way.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_OUT_OFF,
    MODE_ERASE,
    MODE_PROGRAM,
    MODE_IDENT
  } mode_e;

  typedef struct packed {
    logic eraseAll;
    logic progByte;
    logic driveBus;
    logic selId;
  } strobe_t;

endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chipEnN,
  input  logic    writeEnN,
  input  logic    outEnN,
  input  logic    outEnHv,
  input  logic    addrHv,
  output strobe_t strb
);

  mode_e mode;
  logic  weLast;
  logic  weFall;

  // Mode decode: chip enable first, then the supervoltage on output enable.
  always_comb begin
    if (chipEnN)      mode = MODE_STANDBY;
    else if (outEnHv) mode = addrHv ? MODE_ERASE : MODE_PROGRAM;
    else if (outEnN)  mode = MODE_OUT_OFF;
    else if (addrHv)  mode = MODE_IDENT;
    else              mode = MODE_READ;
  end

  // Write-enable edge detection on the system clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weLast <= 1'b1;
    else       weLast <= writeEnN;
  end

  assign weFall = weLast & ~writeEnN;

  always_comb begin
    strb.eraseAll = weFall && (mode == MODE_ERASE);
    strb.progByte = weFall && (mode == MODE_PROGRAM);
    strb.driveBus = (mode == MODE_READ) || (mode == MODE_IDENT);
    strb.selId    = (mode == MODE_IDENT);
  end

endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath
  import bsm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter logic [7:0]  MAKER_CODE  = 8'hBF,
  parameter logic [7:0]  DEVICE_CODE = 8'hC5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic              idAddrOk;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cells[gi] <= '1;
      end else if (strb.eraseAll) begin
        cells[gi] <= '1;
      end else if (strb.progByte && (addr == ADDR_W'(gi))) begin
        cells[gi] <= cells[gi] & dataIn;
      end
    end
  end

  assign idAddrOk = (addr[ADDR_W-1:1] == '0);

  always_comb begin
    if (strb.selId) begin
      if (!idAddrOk)    rdData = '0;
      else if (addr[0]) rdData = DATA_W'(DEVICE_CODE);
      else              rdData = DATA_W'(MAKER_CODE);
    end else begin
      rdData = cells[addr];
    end
  end

  assign dataOut = strb.driveBus ? rdData : '0;

endmodule

// File: rtl/byte_store_model.sv
module byte_store_model
  import bsm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [7:0]  MAKER_CODE  = 8'hBF,
  parameter logic [7:0]  DEVICE_CODE = 8'hC5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic              writeEnN,
  input  logic              outEnN,
  input  logic              outEnHv,
  input  logic              addrHv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOe
);

  strobe_t strb;

  bsm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipEnN  (chipEnN),
    .writeEnN (writeEnN),
    .outEnN   (outEnN),
    .outEnHv  (outEnHv),
    .addrHv   (addrHv),
    .strb     (strb)
  );

  bsm_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (8),
    .MAKER_CODE  (MAKER_CODE),
    .DEVICE_CODE (DEVICE_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  assign dataOe = strb.driveBus;

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  MAKER_CODE = 8'hBF
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipEnN,
  input logic              writeEnN,
  input logic              outEnN,
  input logic              outEnHv,
  input logic              addrHv,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dataOut,
  input logic              dataOe,
  input logic              eraseFire,
  input logic              progFire
);

  AST_HV_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    outEnHv |-> !dataOe);                                          // R1

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    chipEnN |-> (!dataOe && !eraseFire && !progFire));             // R2

  AST_WE_HIGH_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    writeEnN |-> (!eraseFire && !progFire));                       // R7

  AST_ONE_OP_PER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (eraseFire || progFire) |=> !(eraseFire || progFire));         // R9

  AST_ERASE_READS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(eraseFire) && !chipEnN && !outEnN && !outEnHv && !addrHv)
      |-> (dataOut == 8'hFF));                                     // R4

  AST_IDENT_MAKER: assert property (@(posedge clk) disable iff (!rstN)
    (!chipEnN && !outEnN && writeEnN && !outEnHv && addrHv && (addr == '0))
      |-> (dataOe && dataOut == MAKER_CODE));                      // R6

endmodule

bind byte_store_model bsm_checker #(
  .ADDR_W     (ADDR_W),
  .MAKER_CODE (MAKER_CODE)
) u_bsm_checker (
  .clk       (clk),
  .rstN      (rstN),
  .chipEnN   (chipEnN),
  .writeEnN  (writeEnN),
  .outEnN    (outEnN),
  .outEnHv   (outEnHv),
  .addrHv    (addrHv),
  .addr      (addr),
  .dataOut   (dataOut),
  .dataOe    (dataOe),
  .eraseFire (strb.eraseAll),
  .progFire  (strb.progByte)
);

// File: tb/byte_store_model_bench.sv
`timescale 1ns/1ps
module byte_store_model_bench;

  localparam int unsigned ADDR_W = 8;

  typedef struct packed {
    logic       ceN;
    logic       weN;
    logic       oeN;
    logic       oeHv;
    logic       aHv;
    logic [7:0] addr;
    logic [7:0] din;
    logic       chk;
    logic       expOe;
    logic [7:0] expData;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 24;
  // Fields: ceN weN oeN oeHv aHv addr din chk expOe expData req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,8'h00,1'b1,1'b1,8'hFF,8'd10}, // R10 reset contents
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h03,8'hA5,1'b1,1'b0,8'h00,8'd1},  // R1 program setup floats
    '{1'b0,1'b0,1'b1,1'b1,1'b0,8'h03,8'hA5,1'b1,1'b0,8'h00,8'd5},  // R5 program pulse
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h03,8'hA5,1'b0,1'b0,8'h00,8'd5},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,8'h00,1'b1,1'b1,8'hA5,8'd5},  // R5 readback
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h04,8'h00,1'b1,1'b1,8'hFF,8'd11}, // R11 neighbour
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h03,8'h3C,1'b0,1'b0,8'h00,8'd8},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,8'h03,8'h3C,1'b0,1'b0,8'h00,8'd8},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h03,8'h3C,1'b0,1'b0,8'h00,8'd8},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,8'h00,1'b1,1'b1,8'h24,8'd8},  // R8 AND result
    '{1'b1,1'b1,1'b0,1'b1,1'b0,8'h03,8'h00,1'b1,1'b0,8'h00,8'd2},  // R2 standby floats
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h03,8'h00,1'b1,1'b0,8'h00,8'd2},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,8'h03,8'h00,1'b0,1'b0,8'h00,8'd2},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,8'h00,1'b1,1'b1,8'h24,8'd2},  // R2 write ignored
    '{1'b0,1'b1,1'b1,1'b1,1'b0,8'h03,8'h00,1'b0,1'b0,8'h00,8'd7},  // R7 we high, no pulse
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,8'h00,1'b1,1'b1,8'h24,8'd7},  // R7 unchanged
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h00,8'h00,1'b1,1'b1,8'hBF,8'd6},  // R6 maker
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h01,8'h00,1'b1,1'b1,8'hC5,8'd6},  // R6 device
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h03,8'h00,1'b1,1'b1,8'h00,8'd6},  // R6 upper bit set
    '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h03,8'h00,1'b1,1'b0,8'h00,8'd1},  // R1 output disable
    '{1'b0,1'b1,1'b1,1'b1,1'b1,8'h5A,8'h00,1'b1,1'b0,8'h00,8'd3},  // R3 erase setup
    '{1'b0,1'b0,1'b1,1'b1,1'b1,8'hC7,8'h12,1'b0,1'b0,8'h00,8'd3},  // R3 junk addr/data
    '{1'b0,1'b1,1'b1,1'b1,1'b1,8'h5A,8'h00,1'b0,1'b0,8'h00,8'd3},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,8'h00,1'b1,1'b1,8'hFF,8'd4}   // R4 erased
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       chipEnN, writeEnN, outEnN, outEnHv, addrHv;
  logic [7:0] addr, dataIn, dataOut;
  logic       dataOe;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  byte_store_model #(.ADDR_W(ADDR_W)) u_byte_store_model (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .writeEnN(writeEnN),
    .outEnN(outEnN), .outEnHv(outEnHv), .addrHv(addrHv), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: oe/data actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge; sample 1.5 ns later, before the next rising edge.
  task automatic apply(input logic ce, we, oe, hv, ahv, input logic [7:0] a, d);
    @(negedge clk);
    chipEnN = ce; writeEnN = we; outEnN = oe; outEnHv = hv; addrHv = ahv;
    addr = a; dataIn = d;
    #1.5;
  endtask

  task automatic readAt(input logic [7:0] a);
    apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, 8'h00);
  endtask

  initial begin
    rstN = 1'b0; chipEnN = 1'b1; writeEnN = 1'b1; outEnN = 1'b1;
    outEnHv = 1'b0; addrHv = 1'b0; addr = '0; dataIn = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check("R1 reset idle", {dataOe, 8'h00}, {1'b0, 8'h00});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].ceN, VEC[i].weN, VEC[i].oeN, VEC[i].oeHv, VEC[i].aHv,
            VEC[i].addr, VEC[i].din);
      if (VEC[i].chk)
        check($sformatf("R%0d vec %0d", VEC[i].req, i),
              {dataOe, dataOe ? dataOut : 8'h00}, {VEC[i].expOe, VEC[i].expData});
    end

    // R9: long write pulse, data changes while writeEnN stays low.
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h05, 8'hF0);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'hF0);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'h0F);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'h0F);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h05, 8'h0F);
    readAt(8'h05);
    check("R9 single apply", {dataOe, dataOut}, {1'b1, 8'hF0});

    // R5 / R11 at the top address.
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h81);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h81);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h81);
    readAt(8'hFF);
    check("R11 top address", {dataOe, dataOut}, {1'b1, 8'h81});

    // R10: reset after programming restores FFh.
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readAt(8'h05);
    check("R10 reset refill", {dataOe, dataOut}, {1'b1, 8'hFF});
    readAt(8'hFF);
    check("R10 reset refill top", {dataOe, dataOut}, {1'b1, 8'hFF});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule